// File: doc/BRIEF.md
# 8-bit ALU with Flag Update

This block is the arithmetic and logic unit for an 8-bit accumulator datapath. It is purely combinational. It takes an operation code, the accumulator byte, a second operand byte and the current flag vector. It returns a result byte and the next flag vector, together with a per-flag write mask that tells the caller which flags the operation owns. A separate 16-bit adder serves register-pair addition.

The caller routes the register to be incremented or decremented onto `acc_i`. It writes `result_o` back to that register or to the accumulator as the instruction requires. Operations that produce no byte result return `acc_i` unchanged, so writing `result_o` back is always harmless. `flags_o` is already merged: every bit whose write-mask bit is 0 is a copy of `flags_i`. Register storage and operand fetch belong to the caller.

Top module: `byte_alu`

## Requirements
- R1: Flag vectors use bit 4 = sign, bit 3 = zero, bit 2 = auxiliary carry, bit 1 = parity and bit 0 = carry. For every bit whose `flag_we_o` bit is 0, `flags_o` equals `flags_i`.
- R2: Code 0 adds `opnd_i` to `acc_i`, and code 1 also adds the incoming carry. Both set all five flags: carry is the carry out of bit 7 and auxiliary carry is the carry out of bit 3.
- R3: Code 2 computes `acc_i - opnd_i`, and code 3 also subtracts the incoming carry as a borrow. Both set all five flags: carry is the borrow out of bit 7 and auxiliary carry is the borrow out of bit 3.
- R4: Code 4 returns `acc_i + 1` and code 5 returns `acc_i - 1`. The write mask is 0x1E, so carry is kept. Auxiliary carry is the carry or borrow of the low nibble.
- R5: Codes 6, 7 and 8 return the AND, XOR and OR of `acc_i` and `opnd_i`. All three update sign, zero and parity and clear carry. Auxiliary carry is set by AND and cleared by XOR and OR.
- R6: Code 9 (compare) returns `acc_i` unchanged and sets all flags from `acc_i - opnd_i`. Carry is 1 when `acc_i < opnd_i`, zero is 1 when they are equal, and both are 0 when `acc_i` is greater.
- R7: Codes 10 and 11 rotate left and right, copying the leaving bit into both carry and the vacated bit. Codes 12 and 13 rotate left and right through carry. All four have write mask 0x01.
- R8: Code 14 returns `~acc_i` with write mask 0. Code 15 sets carry and code 16 inverts carry; both have write mask 0x01 and return `acc_i`.
- R9: Code 17 (decimal adjust) first adds 6 when the low nibble exceeds 9 or auxiliary carry is set. It then adds 0x60 when the resulting high nibble exceeds 9, carry is set, or the first step overflowed. Carry out is set when the high adjustment happens. Auxiliary carry out is set when the low adjustment carries out of bit 3. A valid BCD byte with both carries clear passes through unchanged.
- R10: `pair_sum_o` is always `pair_a_i + pair_b_i` modulo 2^16. Code 18 sets only carry, to the bit-16 overflow of that sum.
- R11: Whenever sign, zero and parity are written, sign is bit 7 of the value the flags are taken from, zero means that value is 0, and parity is 1 for an even number of one bits.
- R12: Codes 19 to 31 return `acc_i` and have write mask 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator, or the register being incremented or decremented |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 5 | Current flags {S,Z,AC,P,CY} |
| pair_a_i | input | 16 | First register pair for the 16-bit add |
| pair_b_i | input | 16 | Second register pair for the 16-bit add |
| result_o | output | 8 | Result byte |
| pair_sum_o | output | 16 | 16-bit sum |
| flags_o | output | 5 | Next flags, merged with `flags_i` |
| flag_we_o | output | 5 | Per-flag write mask |

## Verification
The unit holds no state. A wrong internal value therefore shows at `result_o`, `flags_o` or `flag_we_o` as soon as the inputs settle, with no latency to wait out. The faults that matter are carry inversion on the subtract path, a wrong nibble boundary for auxiliary carry, and a write mask that leaks a flag. Each of these shows in the same sample as the failing operation. Directed corner values (borrow from zero, increment of 0xFF with carry held, decimal-adjust overflow, 16-bit wrap) are mixed with a pseudo-random sweep over every operation code.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int DW  = 8;
  localparam int FW  = 5;
  localparam int OPW = 5;

  localparam int F_CY = 0;
  localparam int F_P  = 1;
  localparam int F_AC = 2;
  localparam int F_Z  = 3;
  localparam int F_S  = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBB = 5'd3,
    OP_INC = 5'd4,  OP_DEC = 5'd5,  OP_AND = 5'd6,  OP_XOR = 5'd7,
    OP_OR  = 5'd8,  OP_CMP = 5'd9,  OP_RLC = 5'd10, OP_RRC = 5'd11,
    OP_RAL = 5'd12, OP_RAR = 5'd13, OP_CMA = 5'd14, OP_STC = 5'd15,
    OP_CMC = 5'd16, OP_DAA = 5'd17, OP_DAD = 5'd18
  } op_e;
endpackage

// File: rtl/byte_alu_arith.sv
module byte_alu_arith
  import byte_alu_pkg::*;
#(
  parameter int W = DW
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cy_i,
  output logic [W-1:0] res_o,
  output logic         cy_o,
  output logic         ac_o
);
  localparam int NH = W / 2;

  logic         sub;
  logic         cin;
  logic [W-1:0] b_sel;
  logic [W-1:0] b_x;
  logic [NH:0]  lo;
  logic [W:0]   full;

  // subtract is a + ~b + cin; carry outputs are inverted into borrows
  always_comb begin
    sub   = 1'b0;
    cin   = 1'b0;
    b_sel = b_i;
    case (op_i)
      OP_ADC:         cin = cy_i;
      OP_SUB, OP_CMP: begin sub = 1'b1; cin = 1'b1; end
      OP_SBB:         begin sub = 1'b1; cin = ~cy_i; end
      OP_INC:         begin b_sel = '0; cin = 1'b1; end
      OP_DEC:         begin sub = 1'b1; b_sel = W'(1); cin = 1'b1; end
      default:        ;
    endcase
    b_x  = sub ? ~b_sel : b_sel;
    lo   = {1'b0, a_i[NH-1:0]} + {1'b0, b_x[NH-1:0]} + {{NH{1'b0}}, cin};
    full = {1'b0, a_i} + {1'b0, b_x} + {{W{1'b0}}, cin};
  end

  assign res_o = full[W-1:0];
  assign cy_o  = sub ^ full[W];
  assign ac_o  = sub ^ lo[NH];

  always_comb begin
    if (op_i == OP_SUB || op_i == OP_SBB || op_i == OP_CMP) begin
      p_borrow_r3: assert (cy_o == ({1'b0, a_i} <
                           ({1'b0, b_i} + {{W{1'b0}}, (op_i == OP_SBB) & cy_i})))
        else $error("borrow disagrees with magnitude compare");
    end
  end
endmodule

// File: rtl/byte_alu_logic.sv
module byte_alu_logic
  import byte_alu_pkg::*;
#(
  parameter int W = DW
) (
  input  op_e          op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cy_i,
  output logic [W-1:0] res_o,
  output logic         cy_o
);
  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_RLC: begin res_o = {a_i[W-2:0], a_i[W-1]}; cy_o = a_i[W-1]; end
      OP_RRC: begin res_o = {a_i[0], a_i[W-1:1]};   cy_o = a_i[0];   end
      OP_RAL: begin res_o = {a_i[W-2:0], cy_i};     cy_o = a_i[W-1]; end
      OP_RAR: begin res_o = {cy_i, a_i[W-1:1]};     cy_o = a_i[0];   end
      OP_CMA: res_o = ~a_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/byte_alu_bcd.sv
module byte_alu_bcd
  import byte_alu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [W-1:0] a_i,
  input  logic         ac_i,
  input  logic         cy_i,
  output logic [W-1:0] res_o,
  output logic         ac_o,
  output logic         cy_o
);
  localparam int NH = W / 2;

  logic       lo_big;
  logic       lo_fix;
  logic       hi_fix;
  logic [W:0] t1;
  logic [W:0] t2;

  always_comb begin
    lo_big = a_i[NH-1:0] > NH'(9);
    lo_fix = lo_big | ac_i;
    t1     = {1'b0, a_i} + (lo_fix ? (W+1)'(6) : '0);
    // high-nibble test uses the value after the low fix
    hi_fix = (t1[W-1:NH] > NH'(9)) | cy_i | t1[W];
    t2     = t1 + (hi_fix ? (W+1)'(6 << NH) : '0);
  end

  assign res_o = t2[W-1:0];
  assign cy_o  = hi_fix;
  assign ac_o  = lo_fix & lo_big;

  always_comb begin
    if (!ac_i && !cy_i && a_i[NH-1:0] <= NH'(9) && a_i[W-1:NH] <= NH'(9)) begin
      p_bcd_passthru_r9: assert (res_o == a_i && !cy_o && !ac_o)
        else $error("valid BCD byte altered by decimal adjust");
    end
  end
endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int W = DW
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   acc_i,
  input  logic [W-1:0]   opnd_i,
  input  logic [FW-1:0]  flags_i,
  input  logic [2*W-1:0] pair_a_i,
  input  logic [2*W-1:0] pair_b_i,
  output logic [W-1:0]   result_o,
  output logic [2*W-1:0] pair_sum_o,
  output logic [FW-1:0]  flags_o,
  output logic [FW-1:0]  flag_we_o
);
  localparam int PW = 2 * W;

  op_e          op;
  logic [W-1:0] ar_res, lg_res, bcd_res;
  logic         ar_cy, ar_ac, lg_cy, bcd_cy, bcd_ac;
  logic [PW:0]  pair_full;
  logic [W-1:0] res, szp_src;
  logic [FW-1:0] nf, we;

  assign op = op_e'(op_i);

  byte_alu_arith #(.W(W)) u_arith (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .cy_i(flags_i[F_CY]),
    .res_o(ar_res), .cy_o(ar_cy), .ac_o(ar_ac)
  );

  byte_alu_logic #(.W(W)) u_logic (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .cy_i(flags_i[F_CY]),
    .res_o(lg_res), .cy_o(lg_cy)
  );

  byte_alu_bcd #(.W(W)) u_bcd (
    .a_i(acc_i), .ac_i(flags_i[F_AC]), .cy_i(flags_i[F_CY]),
    .res_o(bcd_res), .ac_o(bcd_ac), .cy_o(bcd_cy)
  );

  assign pair_full  = {1'b0, pair_a_i} + {1'b0, pair_b_i};
  assign pair_sum_o = pair_full[PW-1:0];

  always_comb begin
    res     = acc_i;
    szp_src = acc_i;
    nf      = flags_i;
    we      = '0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INC, OP_DEC: begin
        res      = ar_res;
        szp_src  = ar_res;
        nf[F_CY] = ar_cy;
        nf[F_AC] = ar_ac;
        we       = '1;
        if (op == OP_INC || op == OP_DEC) we[F_CY] = 1'b0;
      end
      OP_CMP: begin
        szp_src  = ar_res;
        nf[F_CY] = ar_cy;
        nf[F_AC] = ar_ac;
        we       = '1;
      end
      OP_AND, OP_XOR, OP_OR: begin
        res      = lg_res;
        szp_src  = lg_res;
        nf[F_CY] = 1'b0;
        nf[F_AC] = (op == OP_AND);
        we       = '1;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        res      = lg_res;
        nf[F_CY] = lg_cy;
        we[F_CY] = 1'b1;
      end
      OP_CMA: res = lg_res;
      OP_STC: begin nf[F_CY] = 1'b1;           we[F_CY] = 1'b1; end
      OP_CMC: begin nf[F_CY] = ~flags_i[F_CY]; we[F_CY] = 1'b1; end
      OP_DAA: begin
        res      = bcd_res;
        szp_src  = bcd_res;
        nf[F_CY] = bcd_cy;
        nf[F_AC] = bcd_ac;
        we       = '1;
      end
      OP_DAD: begin nf[F_CY] = pair_full[PW]; we[F_CY] = 1'b1; end
      default: ;
    endcase
    nf[F_S] = szp_src[W-1];
    nf[F_Z] = (szp_src == '0);
    nf[F_P] = ~^szp_src;
  end

  assign result_o  = res;
  assign flag_we_o = we;
  assign flags_o   = (we & nf) | (~we & flags_i);

  always_comb begin
    if (op == OP_CMP) begin
      p_cmp_keeps_acc_r6: assert (result_o == acc_i)
        else $error("compare altered accumulator");
      if (acc_i == opnd_i) begin
        p_cmp_equal_r6: assert (flags_o[F_Z] && !flags_o[F_CY])
          else $error("compare equal flags wrong");
      end
    end
    if (op == OP_AND || op == OP_XOR || op == OP_OR) begin
      p_logic_no_carry_r5: assert (!flags_o[F_CY])
        else $error("logic op left carry set");
    end
    if (op == OP_DAD) begin
      p_pair_carry_r10: assert (flags_o[F_CY] == (pair_sum_o < pair_a_i))
        else $error("pair add carry disagrees with wrap");
    end
    if (op inside {OP_RLC, OP_RRC, OP_RAL, OP_RAR, OP_STC, OP_CMC, OP_DAD}) begin
      p_carry_only_r7: assert (flags_o[FW-1:1] == flags_i[FW-1:1])
        else $error("carry-only op touched another flag");
    end
  end
endmodule

// File: tb/byte_alu_tb_top.sv
`timescale 1ns/1ps
module byte_alu_tb_top;
  localparam logic [4:0] O_ADD = 0,  O_ADC = 1,  O_SUB = 2,  O_SBB = 3,
                         O_INC = 4,  O_DEC = 5,  O_AND = 6,  O_XOR = 7,
                         O_OR  = 8,  O_CMP = 9,  O_RLC = 10, O_RRC = 11,
                         O_RAL = 12, O_RAR = 13, O_CMA = 14, O_STC = 15,
                         O_CMC = 16, O_DAA = 17, O_DAD = 18;

  logic clk = 1'b0;
  always #10 clk = ~clk;
  logic rst_n;

  logic [4:0]  op;
  logic [7:0]  acc, opnd, res;
  logic [4:0]  fl_in, fl_out, we;
  logic [15:0] pa, pb, psum;

  byte_alu dut_i (
    .op_i(op), .acc_i(acc), .opnd_i(opnd), .flags_i(fl_in),
    .pair_a_i(pa), .pair_b_i(pb), .result_o(res), .pair_sum_o(psum),
    .flags_o(fl_out), .flag_we_o(we)
  );

  typedef struct {
    string       tag;
    logic [7:0]  res;
    logic [4:0]  fl;
    logic [4:0]  we;
    logic [15:0] sum;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   fails  = 0;

  function automatic exp_t model(logic [4:0] o, logic [7:0] a, logic [7:0] b,
                                 logic [4:0] f, logic [15:0] x, logic [15:0] y);
    exp_t       e;
    int         r, c, lo;
    logic [7:0] rv, src;
    logic       cy, ac, ncy, nac, lfix, hfix;
    logic [4:0] m, nf;
    cy = f[0]; ac = f[2];
    rv = a; src = a; ncy = cy; nac = ac; m = 5'b0;
    e.tag = "R12";
    e.sum = x + y;
    case (o)
      O_ADD, O_ADC: begin
        c = (o == O_ADC) ? int'(cy) : 0;
        r = int'(a) + int'(b) + c;
        rv = r[7:0]; src = rv; ncy = r > 255;
        nac = (int'(a[3:0]) + int'(b[3:0]) + c) > 15;
        m = 5'b11111; e.tag = "R2";
      end
      O_SUB, O_SBB, O_CMP: begin
        c = (o == O_SBB) ? int'(cy) : 0;
        r = int'(a) - int'(b) - c;
        src = r[7:0]; ncy = r < 0;
        nac = (int'(a[3:0]) - int'(b[3:0]) - c) < 0;
        rv = (o == O_CMP) ? a : src;
        m = 5'b11111; e.tag = (o == O_CMP) ? "R6" : "R3";
      end
      O_INC: begin rv = a + 8'd1; src = rv; nac = (a[3:0] == 4'hF); m = 5'b11110; e.tag = "R4"; end
      O_DEC: begin rv = a - 8'd1; src = rv; nac = (a[3:0] == 4'h0); m = 5'b11110; e.tag = "R4"; end
      O_AND: begin rv = a & b; src = rv; ncy = 0; nac = 1; m = 5'b11111; e.tag = "R5"; end
      O_XOR: begin rv = a ^ b; src = rv; ncy = 0; nac = 0; m = 5'b11111; e.tag = "R5"; end
      O_OR:  begin rv = a | b; src = rv; ncy = 0; nac = 0; m = 5'b11111; e.tag = "R5"; end
      O_RLC: begin rv = {a[6:0], a[7]}; ncy = a[7]; m = 5'b00001; e.tag = "R7"; end
      O_RRC: begin rv = {a[0], a[7:1]}; ncy = a[0]; m = 5'b00001; e.tag = "R7"; end
      O_RAL: begin rv = {a[6:0], cy};   ncy = a[7]; m = 5'b00001; e.tag = "R7"; end
      O_RAR: begin rv = {cy, a[7:1]};   ncy = a[0]; m = 5'b00001; e.tag = "R7"; end
      O_CMA: begin rv = ~a; e.tag = "R8"; end
      O_STC: begin ncy = 1; m = 5'b00001; e.tag = "R8"; end
      O_CMC: begin ncy = ~cy; m = 5'b00001; e.tag = "R8"; end
      O_DAA: begin
        lo   = int'(a[3:0]);
        lfix = (lo > 9) || ac;
        r    = int'(a) + (lfix ? 6 : 0);
        hfix = ((r >> 4) > 9) || cy;
        r    = r + (hfix ? 96 : 0);
        rv = r[7:0]; src = rv; ncy = hfix; nac = lfix && (lo > 9);
        m = 5'b11111; e.tag = "R9";
      end
      O_DAD: begin ncy = (int'(x) + int'(y)) > 65535; m = 5'b00001; e.tag = "R10"; end
      default: ;
    endcase
    nf   = {src[7], src == 8'h00, nac, ~^src, ncy};
    e.fl = (m & nf) | (~m & f);
    e.res = rv;
    e.we  = m;
    return e;
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic [4:0] f, input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    op = o; acc = a; opnd = b; fl_in = f; pa = x; pb = y;
    sb.push_back(model(o, a, b, f, x, y));
  endtask

  // monitor: sample at posedge, half a cycle after the driver changed inputs
  initial begin
    forever begin
      @(posedge clk);
      if (sb.size() != 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, "result", {8'h00, res}, {8'h00, e.res});
        chk({e.tag, " R1 R11"}, "flags", {11'h0, fl_out}, {11'h0, e.fl});
        chk({e.tag, " R1"}, "mask", {11'h0, we}, {11'h0, e.we});
        chk("R10", "pair_sum", psum, e.sum);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all-R act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    op = '0; acc = '0; opnd = '0; fl_in = '0; pa = '0; pb = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // all-zero inputs: R2 zero and even parity
    drive(O_ADD, 8'h00, 8'h00, 5'b00000, 16'h0, 16'h0);
    // R2 nibble carry, full carry, carry-in into sign
    drive(O_ADD, 8'h0F, 8'h01, 5'b00000, 16'h0, 16'h0);
    drive(O_ADD, 8'hFF, 8'h01, 5'b00000, 16'h0, 16'h0);
    drive(O_ADC, 8'h7F, 8'h00, 5'b00001, 16'h0, 16'h0);
    // R3 nibble borrow, borrow from zero, borrow-in
    drive(O_SUB, 8'h10, 8'h01, 5'b00000, 16'h0, 16'h0);
    drive(O_SUB, 8'h00, 8'h01, 5'b00000, 16'h0, 16'h0);
    drive(O_SBB, 8'h05, 8'h05, 5'b00001, 16'h0, 16'h0);
    // R4 carry kept both ways
    drive(O_INC, 8'hFF, 8'h00, 5'b00001, 16'h0, 16'h0);
    drive(O_INC, 8'hFF, 8'h00, 5'b00000, 16'h0, 16'h0);
    drive(O_DEC, 8'h00, 8'h00, 5'b00001, 16'h0, 16'h0);
    // R5
    drive(O_AND, 8'hF0, 8'h3C, 5'b00001, 16'h0, 16'h0);
    drive(O_XOR, 8'hAA, 8'hAA, 5'b00101, 16'h0, 16'h0);
    drive(O_OR,  8'h80, 8'h01, 5'b00101, 16'h0, 16'h0);
    // R6 lower, equal, greater
    drive(O_CMP, 8'h10, 8'h20, 5'b00000, 16'h0, 16'h0);
    drive(O_CMP, 8'h42, 8'h42, 5'b00001, 16'h0, 16'h0);
    drive(O_CMP, 8'h90, 8'h20, 5'b01001, 16'h0, 16'h0);
    // R7 with both carry values
    drive(O_RLC, 8'h81, 8'h00, 5'b11110, 16'h0, 16'h0);
    drive(O_RRC, 8'h81, 8'h00, 5'b00000, 16'h0, 16'h0);
    drive(O_RAL, 8'h40, 8'h00, 5'b00001, 16'h0, 16'h0);
    drive(O_RAR, 8'h01, 8'h00, 5'b00000, 16'h0, 16'h0);
    // R8
    drive(O_CMA, 8'h5A, 8'h00, 5'b10101, 16'h0, 16'h0);
    drive(O_STC, 8'h33, 8'h00, 5'b11110, 16'h0, 16'h0);
    drive(O_CMC, 8'h33, 8'h00, 5'b01011, 16'h0, 16'h0);
    // R9 both adjust, low only via AC, pass-through, overflow from low fix
    drive(O_DAA, 8'h9B, 8'h00, 5'b00000, 16'h0, 16'h0);
    drive(O_DAA, 8'h15, 8'h00, 5'b00100, 16'h0, 16'h0);
    drive(O_DAA, 8'h99, 8'h00, 5'b00000, 16'h0, 16'h0);
    drive(O_DAA, 8'hFC, 8'h00, 5'b00000, 16'h0, 16'h0);
    drive(O_DAA, 8'h12, 8'h00, 5'b00001, 16'h0, 16'h0);
    // R10 wrap and no wrap
    drive(O_DAD, 8'h00, 8'h00, 5'b11110, 16'hFFFF, 16'h0001);
    drive(O_DAD, 8'h00, 8'h00, 5'b00001, 16'h1234, 16'h1111);
    // R12 unused codes
    drive(5'd19, 8'hC3, 8'h11, 5'b10101, 16'h0, 16'h0);
    drive(5'd31, 8'h3C, 8'h11, 5'b01010, 16'h0, 16'h0);
    // sweep over all codes
    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      drive(5'(lf[4:0] % 5'd20), lf[12:5], lf[20:13], lf[25:21], {lf[15:0]}, {lf[31:16]});
    end
    wait (sb.size() == 0);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule